// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This core executes a small 32-bit instruction subset with every instruction finishing in exactly one clock cycle. On each cycle it fetches the word at the program counter, splits out the register and immediate fields, reads two source registers, runs the ALU and chooses the writeback value and the next program counter. The supported operations are word load and store, register add, subtract, AND, OR and signed set-less-than, branch-if-equal and an absolute jump.

Instruction storage and data storage are two separate internal word-addressed arrays. While reset is held, a preload port writes either array, so a program and its initial data can be placed before execution starts. A debug port shows the current program counter and, for every instruction that writes a register, the target register and the value. The host reads these outputs within the cycle, before the clock edge that commits the write.

Top module: `sc_cpu`

## Requirements
- R1: While `rst` is high the PC is 0 and `wb_en_o` is 0. On the first cycle after reset the PC is 0, and all 32 registers read 0.
- R2: While `rst` is high and `load_en` is 1, a rising edge writes `load_data` to word `load_addr` of instruction storage when `load_sel` is 0, or of data storage when `load_sel` is 1.
- R3: An instruction that neither jumps nor takes a branch moves the PC to PC+4 at the next edge. The instruction word is fetched from word index PC[7:2].
- R4: Opcode 000000 is register type: bits 25:21 and 20:16 name the sources and bits 15:11 the destination. Funct 0x20 is add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A signed set-less-than (result 1 or 0). Any other funct writes nothing.
- R5: Opcode 100011 loads the word at the address (bits 25:21 register + sign-extended bits 15:0) into the register named by bits 20:16.
- R6: Opcode 101011 stores the bits 20:16 register to the address formed as in R5, and it writes no register.
- R7: Opcode 000100 compares its two registers. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2. Otherwise it is PC+4. No register is written.
- R8: Opcode 000010 sets the next PC to {PC+4 bits 31:28, instruction bits 25:0, 2'b00} and writes no register.
- R9: Register 0 always reads as 0. A write aimed at it is reported on the debug port but has no effect.
- R10: An instruction that reads the register it writes uses the value held before that write.
- R11: Any other opcode writes no register and no data word, and it advances the PC by 4.
- R12: `wb_en_o`, `wb_reg_o` and `wb_data_o` show the current instruction's register write during the cycle before the edge that commits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; enables preload |
| load_en | input | 1 | Preload write strobe (only while `rst` is high) |
| load_sel | input | 1 | Preload target: 0 instruction storage, 1 data storage |
| load_addr | input | 6 | Preload word index |
| load_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Current instruction writes a register |
| wb_reg_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value being written |

## Verification
The bench uses the default sizes: 64 instruction words, 64 data words and 32 registers. At these sizes a 26-word program fits in storage with room left over. It runs every operation, a store followed by a reload, a taken forward branch past filler words, a jump past filler, an undefined opcode and a one-word branch loop. With 32 registers there are enough free destinations that each result lands in its own register and stays readable for later checks. A second reset phase reloads both storages, to show that registers are cleared and that the data preload takes effect.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    typedef enum logic [5:0] {
        OP_RTYPE = 6'b000000,
        OP_LW    = 6'b100011,
        OP_SW    = 6'b101011,
        OP_BEQ   = 6'b000100,
        OP_J     = 6'b000010
    } opcode_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10,
        AOP_NONE  = 2'b11
    } aluop_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_sel_e;

    typedef struct packed {
        logic   dst_rd;
        logic   reg_we;
        logic   use_imm;
        logic   branch;
        logic   mem_rd;
        logic   mem_we;
        logic   wb_mem;
        aluop_e alu_op;
        logic   jump;
    } ctrl_t;

    typedef struct packed {
        logic     ok;
        alu_sel_e sel;
    } alu_dec_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic alu_dec_t alu_decode(input aluop_e op, input logic [5:0] fn);
        alu_dec_t d;
        d.ok  = 1'b1;
        d.sel = ALU_ADD;
        case (op)
            AOP_ADD:  d.sel = ALU_ADD;
            AOP_SUB:  d.sel = ALU_SUB;
            AOP_FUNCT: begin
                case (fn)
                    FN_ADD:  d.sel = ALU_ADD;
                    FN_SUB:  d.sel = ALU_SUB;
                    FN_AND:  d.sel = ALU_AND;
                    FN_OR:   d.sel = ALU_OR;
                    FN_SLT:  d.sel = ALU_SLT;
                    default: d.ok  = 1'b0;
                endcase
            end
            default:  d.ok = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sc_cpu_ctrl.sv
module sc_cpu_ctrl
    import sc_cpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_sel_e   alu_sel
);
    alu_dec_t dec;

    always_comb begin
        ctrl = '0;
        ctrl.alu_op = AOP_NONE;
        case (opcode)
            OP_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = AOP_FUNCT;
            end
            OP_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.alu_op  = AOP_ADD;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
                ctrl.alu_op  = AOP_ADD;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = AOP_SUB;
            end
            OP_J: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
        dec = alu_decode(ctrl.alu_op, funct);
        if (ctrl.alu_op == AOP_FUNCT && !dec.ok)
            ctrl.reg_we = 1'b0;
        alu_sel = dec.sel;
    end

endmodule

// File: rtl/sc_cpu_regfile.sv
module sc_cpu_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREGS)-1:0] ra1,
    input  logic [$clog2(NREGS)-1:0] ra2,
    output logic [W-1:0]             rd1,
    output logic [W-1:0]             rd2,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] wa,
    input  logic [W-1:0]             wd
);
    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++)
                regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_cpu_alu.sv
module sc_cpu_alu
    import sc_cpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_sel_e     sel,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (sel)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
    import sc_cpu_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    parameter int NREGS   = 32
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         load_en,
    input  logic                                         load_sel,
    input  logic [(IMEM_AW > DMEM_AW ? IMEM_AW : DMEM_AW)-1:0] load_addr,
    input  logic [XLEN-1:0]                              load_data,
    output logic [XLEN-1:0]                              pc_o,
    output logic                                         wb_en_o,
    output logic [REG_AW-1:0]                            wb_reg_o,
    output logic [XLEN-1:0]                              wb_data_o
);
    localparam int IMEM_WORDS = 1 << IMEM_AW;
    localparam int DMEM_WORDS = 1 << DMEM_AW;

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc, pc_plus4, pc_next, br_target, jmp_target;
    logic [XLEN-1:0] instr, imm, rs_val, rt_val, alu_b, alu_res, mem_rdata;
    logic            alu_zero;
    ctrl_t           ctrl;
    alu_sel_e        alu_sel;

    // Fetch
    assign instr = imem[pc[IMEM_AW+1:2]];

    always_ff @(posedge clk) begin
        if (rst && load_en && !load_sel)
            imem[load_addr[IMEM_AW-1:0]] <= load_data;
    end

    // Decode
    sc_cpu_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl),
        .alu_sel(alu_sel)
    );

    assign imm = sext16(instr[15:0]);

    sc_cpu_regfile #(.NREGS(NREGS), .W(XLEN)) u_rf (
        .clk(clk),
        .rst(rst),
        .ra1(instr[25:21]),
        .ra2(instr[20:16]),
        .rd1(rs_val),
        .rd2(rt_val),
        .we (ctrl.reg_we && !rst),
        .wa (wb_reg_o),
        .wd (wb_data_o)
    );

    // Execute
    assign alu_b = ctrl.use_imm ? imm : rt_val;

    sc_cpu_alu #(.W(XLEN)) u_alu (
        .a   (rs_val),
        .b   (alu_b),
        .sel (alu_sel),
        .y   (alu_res),
        .zero(alu_zero)
    );

    // Data storage
    assign mem_rdata = ctrl.mem_rd ? dmem[alu_res[DMEM_AW+1:2]] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            if (load_en && load_sel)
                dmem[load_addr[DMEM_AW-1:0]] <= load_data;
        end else if (ctrl.mem_we) begin
            dmem[alu_res[DMEM_AW+1:2]] <= rt_val;
        end
    end

    // Writeback selection
    assign wb_reg_o  = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign wb_data_o = ctrl.wb_mem ? mem_rdata : alu_res;
    assign wb_en_o   = ctrl.reg_we && !rst;

    // Next PC
    assign pc_plus4   = pc + 32'd4;
    assign br_target  = pc_plus4 + {imm[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        pc_next = pc_plus4;
        if (ctrl.jump)
            pc_next = jmp_target;
        else if (ctrl.branch && alu_zero)
            pc_next = br_target;
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    assign pc_o = pc;

endmodule

// File: rtl/sc_cpu_chk.sv
module sc_cpu_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        wb_en_o
);
    logic is_j, is_beq, is_sw;
    assign is_j   = instr[31:26] == 6'b000010;
    assign is_beq = instr[31:26] == 6'b000100;
    assign is_sw  = instr[31:26] == 6'b101011;

    // R1
    reset_pc_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_o == 32'd0));

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_j && !(is_beq && rs_val == rt_val)) |=> (pc_o == $past(pc_o) + 32'd4));

    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        is_j |=> (pc_o == {$past(pc_o + 32'd4) >> 28, $past(instr[25:0]), 2'b00}));

    // R7
    branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (is_beq && rs_val == rt_val) |=>
            (pc_o == $past(pc_o) + 32'd4 + {$past({{14{instr[15]}}, instr[15:0]}), 2'b00}));

    // R9
    zero_reg_read_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

    // R6
    no_store_write_chk: assert property (@(posedge clk) disable iff (rst)
        (is_sw || is_beq || is_j) |-> !wb_en_o);

endmodule

bind sc_cpu sc_cpu_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc_o   (pc_o),
    .instr  (instr),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .wb_en_o(wb_en_o)
);

// File: tb/test_sc_cpu.sv
`timescale 1ns/1ps
module test_sc_cpu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_sel = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o;
    logic        wb_en_o;
    logic [4:0]  wb_reg_o;
    logic [31:0] wb_data_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    sc_cpu i_sc_cpu (
        .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel),
        .load_addr(load_addr), .load_data(load_data), .pc_o(pc_o),
        .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o), .wb_data_o(wb_data_o)
    );

    localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;
    localparam logic [5:0] ADD = 6'h20, SUB = 6'h22, AND_ = 6'h24, OR_ = 6'h25, SLT = 6'h2A;

    function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, logic [15:0] im);
        return {op, rs[4:0], rt[4:0], im};
    endfunction

    // {pc, wb_en, wb_reg, wb_data}
    localparam int NV = 24;
    localparam logic [69:0] EXP [NV] = '{
        {32'd0,   1'b1, 5'd1,  32'd5},
        {32'd4,   1'b1, 5'd2,  32'd12},
        {32'd8,   1'b1, 5'd3,  32'hFFFFFFF0},
        {32'd12,  1'b1, 5'd4,  32'd17},
        {32'd16,  1'b1, 5'd5,  32'hFFFFFFF9},
        {32'd20,  1'b1, 5'd6,  32'd4},
        {32'd24,  1'b1, 5'd7,  32'd13},
        {32'd28,  1'b1, 5'd8,  32'd1},
        {32'd32,  1'b1, 5'd9,  32'd0},
        {32'd36,  1'b1, 5'd0,  32'd17},
        {32'd40,  1'b0, 5'd0,  32'd0},
        {32'd44,  1'b1, 5'd11, 32'd17},
        {32'd48,  1'b1, 5'd10, 32'd0},
        {32'd52,  1'b1, 5'd1,  32'd10},
        {32'd56,  1'b1, 5'd12, 32'd10},
        {32'd60,  1'b0, 5'd0,  32'd0},
        {32'd64,  1'b0, 5'd0,  32'd0},
        {32'd76,  1'b0, 5'd0,  32'd0},
        {32'd80,  1'b0, 5'd0,  32'd0},
        {32'd92,  1'b0, 5'd0,  32'd0},
        {32'd96,  1'b1, 5'd13, 32'hFFFFFFF9},
        {32'd100, 1'b0, 5'd0,  32'd0},
        {32'd100, 1'b0, 5'd0,  32'd0},
        {32'd100, 1'b0, 5'd0,  32'd0}
    };
    string TAG [NV] = '{"R2","R3","R5","R4","R4","R4","R4","R4","R4","R9","R6","R6",
                        "R9","R10","R10","R7","R7","R7","R11","R8","R6","R7","R7","R12"};

    task automatic check_vec(string tag, logic [69:0] exp);
        logic [69:0] act;
        logic        bad;
        act = {pc_o, wb_en_o, wb_reg_o, wb_data_o};
        bad = (act[69:37] != exp[69:37]) || (exp[37] && act[36:0] != exp[36:0]);
        n_checks++;
        if (bad) begin
            n_fails++;
            $display("FAIL %s: pc=%0d en=%0b reg=%0d data=%h expected pc=%0d en=%0b reg=%0d data=%h",
                     tag, act[69:38], act[37], act[36:32], act[31:0],
                     exp[69:38], exp[37], exp[36:32], exp[31:0]);
        end
    endtask

    task automatic preload(logic sel, int addr, logic [31:0] data);
        @(negedge clk);
        load_en = 1'b1; load_sel = sel; load_addr = addr[5:0]; load_data = data;
        @(posedge clk);
        #1 load_en = 1'b0;
    endtask

    logic [31:0] prog [26];

    initial begin
        prog[0]  = itype(LW, 0, 1, 16'd0);
        prog[1]  = itype(LW, 0, 2, 16'd4);
        prog[2]  = itype(LW, 0, 3, 16'd8);
        prog[3]  = rtype(1, 2, 4, ADD);
        prog[4]  = rtype(1, 2, 5, SUB);
        prog[5]  = rtype(1, 2, 6, AND_);
        prog[6]  = rtype(1, 2, 7, OR_);
        prog[7]  = rtype(3, 1, 8, SLT);
        prog[8]  = rtype(1, 3, 9, SLT);
        prog[9]  = rtype(1, 2, 0, ADD);
        prog[10] = itype(SW, 0, 4, 16'd12);
        prog[11] = itype(LW, 0, 11, 16'd12);
        prog[12] = rtype(0, 0, 10, ADD);
        prog[13] = rtype(1, 1, 1, ADD);
        prog[14] = rtype(1, 0, 12, ADD);
        prog[15] = itype(BEQ, 1, 2, 16'd5);
        prog[16] = itype(BEQ, 4, 11, 16'd2);
        prog[17] = rtype(1, 1, 13, ADD);
        prog[18] = rtype(1, 1, 13, ADD);
        prog[19] = itype(6'b001000, 1, 1, 16'd7);
        prog[20] = {6'b000010, 26'd23};
        prog[21] = rtype(1, 1, 13, ADD);
        prog[22] = rtype(1, 1, 13, ADD);
        prog[23] = itype(SW, 2, 5, 16'hFFFC);
        prog[24] = itype(LW, 0, 13, 16'd8);
        prog[25] = itype(BEQ, 0, 0, 16'hFFFF);

        // Preload under reset
        rst = 1'b1;
        for (int i = 0; i < 26; i++) preload(1'b0, i, prog[i]);
        preload(1'b1, 0, 32'd5);
        preload(1'b1, 1, 32'd12);
        preload(1'b1, 2, 32'hFFFFFFF0);

        // R1: reset state
        @(negedge clk); #1;
        check_vec("R1", {32'd0, 1'b0, 5'd0, 32'd0});

        @(negedge clk);
        rst = 1'b0;
        #1 check_vec(TAG[0], EXP[0]);
        for (int v = 1; v < NV; v++) begin
            @(negedge clk); #1;
            check_vec(TAG[v], EXP[v]);
        end

        // Second phase: registers cleared by reset, data preload visible
        @(negedge clk);
        rst = 1'b1;
        preload(1'b0, 0, rtype(13, 12, 14, ADD));
        preload(1'b0, 1, rtype(3, 0, 15, OR_));
        preload(1'b0, 2, itype(LW, 0, 16, 16'd4));
        preload(1'b1, 1, 32'd99);
        @(negedge clk); #1;
        check_vec("R1", {32'd0, 1'b0, 5'd0, 32'd0});
        @(negedge clk);
        rst = 1'b0;
        #1 check_vec("R1", {32'd0, 1'b1, 5'd14, 32'd0});
        @(negedge clk); #1;
        check_vec("R1", {32'd4, 1'b1, 5'd15, 32'd0});
        @(negedge clk); #1;
        check_vec("R2", {32'd8, 1'b1, 5'd16, 32'd99});

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule